// File: doc/BRIEF.md
# Cascadable Down-Counter Pair with Coherent Nibble Readout

This block holds two 8-bit down-counters, a low timer and a high timer, each with its own reload register. In split mode each timer counts on its own run enable. When a timer leaves zero it takes its reload value and raises a one-cycle underflow pulse. In chained mode the two timers act as one 16-bit counter. The high timer then steps only when the low timer wraps, and only the high timer reports underflow.

Software reads the count 4 bits at a time through a registered nibble port. In chained mode the four reads can straddle a carry from the low byte into the high byte. To keep such a multi-read coherent, a read of the lowest nibble snapshots the upper twelve bits into a hold register, and the counters keep running. Later reads of the upper nibbles return the snapshot, in any order, until the next lowest-nibble read. A small readout state machine tracks whether a snapshot is valid. It has two states. SNAP_IDLE means no valid snapshot. SNAP_HELD means a snapshot is valid. There are two transitions. CAPTURE goes from SNAP_IDLE to SNAP_HELD on a chained read of nibble 0. RELEASE goes from SNAP_HELD to SNAP_IDLE when chained mode is cleared. A chained read of nibble 0 while in SNAP_HELD takes a fresh snapshot and stays in SNAP_HELD.

Top module: `cascade_timer`

## Requirements
- R1: While reset is asserted and right after it is released, both counts, both reload values, `uf_pulse` and `rd_data` are zero, and the readout machine is in SNAP_IDLE.
- R2: In split mode (`chain_en`=0), timer i with `run[i]`=1 and no preset decrements by one per cycle. When it steps at count zero it loads its reload value, and `uf_pulse[i]` is high for exactly the following cycle.
- R3: `rld_we[i]` writes `rld_wdata` into reload register i. A wrap or preset in that same cycle still uses the earlier reload value. `preset[i]` loads count i from its reload register without an underflow pulse, and it takes priority over stepping.
- R4: In chained mode, `run[1]` has no effect. The high timer steps only in a cycle with `run[0]`=1, a low count of zero, and no `preset[0]`.
- R5: In chained mode, `uf_pulse[0]` stays low. `uf_pulse[1]` pulses the cycle after the high timer steps at zero.
- R6: A read (`rd_en`=1) returns data on `rd_data` in the next cycle. Nibble address n selects bits [4n+3:4n] of the word {high count, low count} as it stood in the read cycle. `rd_data` holds its value in cycles without a read.
- R7: In chained mode, a read of nibble 0 returns the live bits [3:0] and copies live bits [15:4] into the hold register (CAPTURE into SNAP_HELD).
- R8: In SNAP_HELD with chained mode on, reads of nibbles 1 to 3 return the held bits, in any order, while the counters keep running.
- R9: In chained mode and SNAP_IDLE, reads of nibbles 1 to 3 return live bits and take no snapshot.
- R10: In split mode, every read returns live bits. Clearing `chain_en` moves the machine to SNAP_IDLE (RELEASE), so a snapshot does not survive a trip out of chained mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chain_en | input | 1 | 1 = the two timers form one 16-bit counter |
| run | input | 2 | Count enable per timer; bit 1 is unused when chained |
| preset | input | 2 | Load count i from its reload register |
| rld_we | input | 2 | Write enable for reload register i |
| rld_wdata | input | 8 | Reload write data |
| rd_en | input | 1 | Nibble read strobe |
| rd_addr | input | 2 | Nibble index into {high, low} count |
| rd_data | output | 4 | Registered read data |
| uf_pulse | output | 2 | One-cycle underflow pulse per timer |

## Verification
The bench aims at the carry from the low byte into the high byte in the middle of a multi-nibble read. A design that did not snapshot there would return a mixed value from before and after the carry. It then reads the upper nibbles before any lowest-nibble read, and again after a trip out of chained mode. A design that kept a stale snapshot would return old bits where live bits are due. It also checks that the low timer's wrap is not reported in chained mode, and that the high timer ignores its own run bit in chained mode. A wrong design would pulse `uf_pulse[0]` there, or let the high count drift. Finally it writes reload registers in the same cycle as wraps and presets, which exposes a design that takes the new reload value one cycle early.

// File: rtl/cascade_timer_pkg.sv
package cascade_timer_pkg;
    // Readout snapshot tracking
    typedef enum logic {
        SNAP_IDLE = 1'b0,
        SNAP_HELD = 1'b1
    } snap_state_e;
endpackage

// File: rtl/cascade_timer_cnt.sv
module cascade_timer_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rld_we,
    input  logic [W-1:0] rld_wdata,
    input  logic         preset,
    input  logic         step,
    input  logic         uf_mask,
    output logic [W-1:0] cnt_q,
    output logic         at_zero,
    output logic         uf_q
);
    logic [W-1:0] rld_q;

    assign at_zero = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rld_q <= '0;
            cnt_q <= '0;
            uf_q  <= 1'b0;
        end else begin
            uf_q <= 1'b0;
            if (rld_we) begin
                rld_q <= rld_wdata;
            end
            if (preset) begin
                cnt_q <= rld_q;
            end else if (step) begin
                if (at_zero) begin
                    cnt_q <= rld_q;
                    uf_q  <= ~uf_mask;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cascade_timer_snap.sv
module cascade_timer_snap
    import cascade_timer_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int NIB_W = 4,
    localparam int WORD_W = 2 * CNT_W,
    localparam int NIB_N  = WORD_W / NIB_W,
    localparam int ADDR_W = $clog2(NIB_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chain_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] cnt_word,
    output logic [NIB_W-1:0]  rd_data,
    output snap_state_e       state_q
);
    snap_state_e              state_d;
    logic [WORD_W-NIB_W-1:0]  hold_q;
    logic [WORD_W-1:0]        held_word;
    logic [NIB_W-1:0]         live_nib;
    logic [NIB_W-1:0]         held_nib;
    logic [NIB_W-1:0]         rd_q;
    logic                     low_read;
    logic                     use_hold;
    int                       sh;

    assign sh        = int'(rd_addr) * NIB_W;
    assign low_read  = rd_en && chain_en && (rd_addr == '0);
    assign held_word = {hold_q, {NIB_W{1'b0}}};
    assign live_nib  = cnt_word[sh +: NIB_W];
    assign held_nib  = held_word[sh +: NIB_W];
    assign use_hold  = chain_en && (state_q == SNAP_HELD) && (rd_addr != '0);
    assign rd_data   = rd_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SNAP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: CAPTURE and RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SNAP_IDLE: if (low_read)  state_d = SNAP_HELD;
            SNAP_HELD: if (!chain_en) state_d = SNAP_IDLE;
            default:                  state_d = SNAP_IDLE;
        endcase
    end

    // outputs: hold register and read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            rd_q   <= '0;
        end else begin
            if (low_read) begin
                hold_q <= cnt_word[WORD_W-1:NIB_W];
            end
            if (rd_en) begin
                rd_q <= use_hold ? held_nib : live_nib;
            end
        end
    end
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
    import cascade_timer_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int NIB_W = 4,
    localparam int WORD_W = 2 * CNT_W,
    localparam int NIB_N  = WORD_W / NIB_W,
    localparam int ADDR_W = $clog2(NIB_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chain_en,
    input  logic [1:0]        run,
    input  logic [1:0]        preset,
    input  logic [1:0]        rld_we,
    input  logic [CNT_W-1:0]  rld_wdata,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [NIB_W-1:0]  rd_data,
    output logic [1:0]        uf_pulse
);
    logic [CNT_W-1:0]  cnt   [2];
    logic [1:0]        zero;
    logic [1:0]        step;
    logic [1:0]        mask;
    logic [WORD_W-1:0] cnt_word;
    snap_state_e       snap_state;

    // high timer follows the low timer's wrap when chained
    assign step[0] = run[0];
    assign step[1] = chain_en ? (run[0] && zero[0] && !preset[0]) : run[1];
    assign mask[0] = chain_en;
    assign mask[1] = 1'b0;
    assign cnt_word = {cnt[1], cnt[0]};

    for (genvar gi = 0; gi < 2; gi++) begin : g_tmr
        cascade_timer_cnt #(.W(CNT_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .rld_we    (rld_we[gi]),
            .rld_wdata (rld_wdata),
            .preset    (preset[gi]),
            .step      (step[gi]),
            .uf_mask   (mask[gi]),
            .cnt_q     (cnt[gi]),
            .at_zero   (zero[gi]),
            .uf_q      (uf_pulse[gi])
        );
    end

    cascade_timer_snap #(.CNT_W(CNT_W), .NIB_W(NIB_W)) u_snap (
        .clk      (clk),
        .rst_n    (rst_n),
        .chain_en (chain_en),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .cnt_word (cnt_word),
        .rd_data  (rd_data),
        .state_q  (snap_state)
    );
endmodule

// File: rtl/cascade_timer_chk.sv
module cascade_timer_chk #(
    parameter int CNT_W = 8,
    parameter int NIB_W = 4,
    localparam int WORD_W = 2 * CNT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chain_en,
    input logic [1:0]        run,
    input logic [1:0]        preset,
    input logic              rd_en,
    input logic [NIB_W-1:0]  rd_data,
    input logic [1:0]        uf_pulse,
    input logic [WORD_W-1:0] cnt_word
);
    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |-> (uf_pulse == 2'b00 && rd_data == '0)); // R1

    AST_SPLIT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(!chain_en && run[0] && !preset[0] && cnt_word[CNT_W-1:0] != '0)
        |-> cnt_word[CNT_W-1:0] == $past(cnt_word[CNT_W-1:0]) - 1'b1); // R2

    AST_HIGH_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(chain_en && !preset[1] && !(run[0] && !preset[0] && cnt_word[CNT_W-1:0] == '0))
        |-> cnt_word[WORD_W-1:CNT_W] == $past(cnt_word[WORD_W-1:CNT_W])); // R4

    AST_CHAIN_NO_LOW_UF: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(chain_en) |-> !uf_pulse[0]); // R5

    AST_RD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(rd_en) |-> $stable(rd_data)); // R6
endmodule

bind cascade_timer cascade_timer_chk #(.CNT_W(CNT_W), .NIB_W(NIB_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .chain_en (chain_en),
    .run      (run),
    .preset   (preset),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .uf_pulse (uf_pulse),
    .cnt_word (cnt_word)
);

// File: tb/cascade_timer_tb.sv
module cascade_timer_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       chain_en;
    logic [1:0] run, preset, rld_we;
    logic [7:0] rld_wdata;
    logic       rd_en;
    logic [1:0] rd_addr;
    logic [3:0] rd_data;
    logic [1:0] uf_pulse;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    logic [7:0]  m_cnt [2];
    logic [7:0]  m_rld [2];
    logic        m_held;
    logic [11:0] m_hold;
    logic [1:0]  e_uf;
    logic [3:0]  e_rd;
    string       e_rtag;
    string       e_utag;

    cascade_timer u_dut (
        .clk(clk), .rst_n(rst_n), .chain_en(chain_en), .run(run),
        .preset(preset), .rld_we(rld_we), .rld_wdata(rld_wdata),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .uf_pulse(uf_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] nib_of(input logic [15:0] w, input logic [1:0] a);
        return 4'((w >> (int'(a) * 4)) & 16'h000f);
    endfunction

    // compare last cycle's expectation, then apply new inputs and predict
    task automatic cyc(input logic c, input logic [1:0] r, input logic [1:0] p,
                       input logic [1:0] we, input logic [7:0] wd,
                       input logic re, input logic [1:0] a, input string tg);
        logic [7:0]  n_cnt [2];
        logic [1:0]  st, w;
        logic [15:0] word;
        @(negedge clk);
        chk(uf_pulse == e_uf, e_utag, uf_pulse, e_uf);
        chk(rd_data == e_rd, e_rtag, rd_data, e_rd);
        chain_en = c; run = r; preset = p; rld_we = we; rld_wdata = wd;
        rd_en = re; rd_addr = a;
        st[0] = r[0];
        st[1] = c ? (r[0] && m_cnt[0] == 8'd0 && !p[0]) : r[1];
        for (int i = 0; i < 2; i++) begin
            w[i] = 1'b0;
            n_cnt[i] = m_cnt[i];
            if (p[i]) n_cnt[i] = m_rld[i];
            else if (st[i]) begin
                if (m_cnt[i] == 8'd0) begin n_cnt[i] = m_rld[i]; w[i] = 1'b1; end
                else n_cnt[i] = m_cnt[i] - 8'd1;
            end
        end
        e_uf   = {w[1], w[0] && !c};
        e_utag = c ? "R5 uf" : "R2 uf";
        word   = {m_cnt[1], m_cnt[0]};
        e_rtag = "R6 hold rd";
        if (re) begin
            if (c && a == 2'd0) begin
                e_rd = word[3:0]; e_rtag = "R7 low capture";
            end else if (c && m_held) begin
                e_rd = nib_of({m_hold, 4'h0}, a); e_rtag = "R8 held read";
            end else begin
                e_rd = nib_of(word, a); e_rtag = c ? "R9 live chained" : "R10 live split";
            end
            if (tg != "") e_rtag = tg;
        end
        if (!c) m_held = 1'b0;
        else if (re && a == 2'd0) begin m_held = 1'b1; m_hold = word[15:4]; end
        for (int i = 0; i < 2; i++) begin
            m_cnt[i] = n_cnt[i];
            if (we[i]) m_rld[i] = wd;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; chain_en = 1'b0; run = '0; preset = '0; rld_we = '0;
        rld_wdata = '0; rd_en = 1'b0; rd_addr = '0;
        for (int i = 0; i < 2; i++) begin m_cnt[i] = '0; m_rld[i] = '0; end
        m_held = 1'b0; m_hold = '0; e_uf = '0; e_rd = '0;
        e_rtag = "R1 reset rd"; e_utag = "R1 reset uf";
        repeat (3) @(negedge clk);
        chk(uf_pulse == 2'b00, "R1 uf in reset", uf_pulse, 0);
        chk(rd_data == 4'h0, "R1 rd in reset", rd_data, 0);
        rst_n = 1'b1;
        // R1: all nibbles read zero after reset
        for (int k = 0; k < 4; k++) cyc(0, 2'b00, 2'b00, 2'b00, 8'h00, 1, 2'(k), "R1 reset count");
        // R3: reload write then preset
        cyc(0, 2'b00, 2'b00, 2'b01, 8'h05, 0, 0, "");
        cyc(0, 2'b00, 2'b01, 2'b00, 8'h00, 0, 0, "");
        cyc(0, 2'b00, 2'b00, 2'b00, 8'h00, 1, 0, "R3 preset load");
        // R3: preset in same cycle as write uses earlier reload
        cyc(0, 2'b00, 2'b01, 2'b01, 8'h09, 1, 0, "R3 old reload");
        cyc(0, 2'b00, 2'b00, 2'b00, 8'h00, 1, 0, "R3 old reload");
        // R2: split countdown with wrap
        for (int k = 0; k < 12; k++) cyc(0, 2'b01, 2'b00, 2'b00, 8'h00, 1, 0, "R2 split count");
        // R4: chained, run[1] alone has no effect
        cyc(1, 2'b00, 2'b00, 2'b10, 8'h12, 0, 0, "");
        cyc(1, 2'b00, 2'b10, 2'b00, 8'h00, 0, 0, "");
        for (int k = 0; k < 5; k++) cyc(1, 2'b10, 2'b00, 2'b00, 8'h00, 0, 0, "");
        cyc(1, 2'b00, 2'b00, 2'b00, 8'h00, 1, 2'd2, "R4 high untouched");
        // R9: upper read before any low read
        cyc(1, 2'b00, 2'b00, 2'b00, 8'h00, 1, 2'd3, "R9 no capture yet");
        // R7/R8: capture near a carry, read upper nibbles out of order while running
        cyc(1, 2'b00, 2'b00, 2'b01, 8'h01, 0, 0, "");
        cyc(1, 2'b00, 2'b01, 2'b00, 8'h00, 0, 0, "");
        cyc(1, 2'b01, 2'b00, 2'b00, 8'h00, 1, 2'd0, "R7 capture");
        cyc(1, 2'b01, 2'b00, 2'b00, 8'h00, 1, 2'd3, "R8 held n3");
        cyc(1, 2'b01, 2'b00, 2'b00, 8'h00, 1, 2'd1, "R8 held n1");
        cyc(1, 2'b01, 2'b00, 2'b00, 8'h00, 1, 2'd2, "R8 held n2");
        // R5: chained wraps, low pulse suppressed
        cyc(1, 2'b00, 2'b00, 2'b11, 8'h00, 0, 0, "");
        cyc(1, 2'b00, 2'b11, 2'b00, 8'h00, 0, 0, "");
        for (int k = 0; k < 4; k++) cyc(1, 2'b01, 2'b00, 2'b00, 8'h00, 0, 0, "");
        // R10: leave chain mode, snapshot released
        cyc(0, 2'b00, 2'b00, 2'b00, 8'h00, 1, 2'd2, "R10 live split");
        cyc(1, 2'b00, 2'b00, 2'b00, 8'h00, 1, 2'd1, "R10 released");
        // constrained random
        for (int k = 0; k < 6000; k++) begin
            logic c;
            logic [7:0] wd;
            c = ((k / 300) % 2) == 1;
            wd = ($urandom % 2) ? 8'($urandom % 6) : 8'($urandom);
            cyc(c, 2'(($urandom % 4 != 0) ? 2'b01 : 2'b00) | 2'(($urandom % 2) << 1),
                2'(($urandom % 64 == 0) ? $urandom % 4 : 0),
                2'(($urandom % 32 == 0) ? $urandom % 4 : 0), wd,
                ($urandom % 3) == 0, 2'($urandom % 4), "");
        end
        cyc(0, 2'b00, 2'b00, 2'b00, 8'h00, 0, 0, "");
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule